// File: doc/BRIEF.md
# Vertical Countdown Timebase

This block produces a clean field reference for a video timing chain from a raw vertical sync signal and a raw horizontal sync signal. Both inputs are first brought to an active-high form by a per-input polarity select and synchronized to the pixel clock. A rising edge of the active horizontal level advances a line counter. The vertical input must hold its active level for a run of consecutive clocks (the integration time, nominally about 31 us, or 444 clocks at 14.318 MHz) before it is treated as a vertical pulse.

A qualified vertical pulse is accepted only while the line counter sits inside the window from `WIN_LO` to `WIN_HI` lines, inclusive (232 and 296 by default). An accepted pulse emits a one-clock `vreset` and restarts the line count. Any pulse that falls outside the window is discarded. When the count reaches `WIN_HI` with no accepted pulse, the next line edge forces a free-running `vreset` instead. A lock flag rises once `LOCK_FIELDS` accepted pulses have arrived without a free-run reset between them, and drops on any free-run reset.

Top module: `vsync_countdown`

## Requirements
- R1: `vpol` = 0 makes a high level on `vsync_in` the active level; `vpol` = 1 makes a low level active.
- R2: `hpol` = 0 makes a high level on `hsync_in` active and `hpol` = 1 a low level. Each transition of the synchronized horizontal input into its active level advances `line_count` by one.
- R3: A vertical pulse qualifies only after `INTEG_CLKS` consecutive synchronized active samples. A shorter active run produces no `vreset`. A single active run qualifies at most once.
- R4: A qualified pulse that arrives while `line_count` is within [`WIN_LO`, `WIN_HI`] drives `vreset` high for exactly one clock, and `line_count` reads 0 in that same cycle.
- R5: A qualified pulse that arrives while `line_count` is below `WIN_LO` is ignored. No `vreset` follows and the line count keeps advancing from its current value.
- R6: A line edge that arrives while `line_count` equals `WIN_HI` and no pulse is being accepted produces a one-clock `vreset`, returns `line_count` to 0 and clears `locked`.
- R7: `locked` rises in the cycle of the `LOCK_FIELDS`-th accepted pulse counted since reset or since the last free-run reset. It changes only in cycles where `vreset` is high.
- R8: While `rst_n` is low and in the first cycle after it rises, `vreset` = 0, `line_count` = 0 and `locked` = 0.
- R9: `line_count` never exceeds `WIN_HI`. Apart from `vreset` cycles, it changes only by incrementing by one.
- R10: When an accepted pulse and a line edge occur in the same cycle, the acceptance wins: `line_count` goes to 0 and that line is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync level |
| hpol | input | 1 | Horizontal active level select (0 high, 1 low) |
| vsync_in | input | 1 | Raw vertical sync level |
| vpol | input | 1 | Vertical active level select (0 high, 1 low) |
| vreset | output | 1 | One-clock field start pulse, accepted or free-running |
| line_count | output | $clog2(WIN_HI+1) | Lines counted since the last `vreset` |
| locked | output | 1 | Set after enough consecutive accepted fields |

## Verification
A line counter that is off by one shows at once on `line_count` and, before the field is out, moves the free-run `vreset` by one whole line. An integration counter that starts too early or runs too long shifts the accepted `vreset` by clock cycles within the same line, or suppresses it. The per-clock reference comparison catches this on the first cycle it appears. A fault in the field tally shows only on the lock edge, which arrives one accepted field early or late. For that reason the bench checks `locked` after each of the fields leading up to lock.

// File: rtl/vsct_pkg.sv
package vsct_pkg;

   typedef enum logic [1:0] {
      VSCT_EV_NONE    = 2'd0,
      VSCT_EV_ACCEPT  = 2'd1,
      VSCT_EV_FREERUN = 2'd2
   } vsct_event_e;

endpackage

// File: rtl/vsct_level_sync.sv
module vsct_level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic invert,
   output logic lvl
);
   logic act;
   assign act = raw ^ invert;

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= act;
         end
         assign lvl = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], act};
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/vsct_integrator.sv
module vsct_integrator #(
   parameter int INTEG_CLKS = 444
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic qual
);
   localparam int CW = $clog2(INTEG_CLKS + 1);
   localparam logic [CW-1:0] LAST = CW'(INTEG_CLKS - 1);
   localparam logic [CW-1:0] FULL = CW'(INTEG_CLKS);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         qual    <= 1'b0;
      end else begin
         qual <= lvl && (run_cnt == LAST);
         if (!lvl)                run_cnt <= '0;
         else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vsct_window_ctr.sv
module vsct_window_ctr
   import vsct_pkg::*;
#(
   parameter int WIN_LO = 232,
   parameter int WIN_HI = 296,
   parameter int LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual,
   input  logic              h_lvl,
   output logic [LINE_W-1:0] line_count,
   output logic              vreset,
   output vsct_event_e       ev
);
   localparam logic [LINE_W-1:0] LO_V = LINE_W'(WIN_LO);
   localparam logic [LINE_W-1:0] HI_V = LINE_W'(WIN_HI);

   logic h_prev;
   logic h_rise;
   logic in_win;

   assign h_rise = h_lvl & ~h_prev;
   assign in_win = (line_count >= LO_V) && (line_count <= HI_V);

   always_comb begin
      if (qual && in_win)                      ev = VSCT_EV_ACCEPT;
      else if (h_rise && (line_count == HI_V)) ev = VSCT_EV_FREERUN;
      else                                     ev = VSCT_EV_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_prev     <= 1'b0;
         line_count <= '0;
         vreset     <= 1'b0;
      end else begin
         h_prev <= h_lvl;
         vreset <= (ev != VSCT_EV_NONE);
         if (ev != VSCT_EV_NONE) line_count <= '0;
         else if (h_rise)        line_count <= line_count + 1'b1;
      end
   end
endmodule

// File: rtl/vsct_lock.sv
module vsct_lock
   import vsct_pkg::*;
#(
   parameter int LOCK_FIELDS = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  vsct_event_e ev,
   output logic        locked
);
   localparam int KW = $clog2(LOCK_FIELDS + 1);
   localparam logic [KW-1:0] GOAL = KW'(LOCK_FIELDS);

   logic [KW-1:0] good_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         locked   <= 1'b0;
      end else begin
         case (ev)
            VSCT_EV_ACCEPT: begin
               if (good_cnt != GOAL) good_cnt <= good_cnt + 1'b1;
               if (good_cnt >= GOAL - 1'b1) locked <= 1'b1;
            end
            VSCT_EV_FREERUN: begin
               good_cnt <= '0;
               locked   <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vsync_countdown.sv
module vsync_countdown
   import vsct_pkg::*;
#(
   parameter  int SYNC_STAGES = 2,
   parameter  int INTEG_CLKS  = 444,
   parameter  int WIN_LO      = 232,
   parameter  int WIN_HI      = 296,
   parameter  int LOCK_FIELDS = 4,
   localparam int LINE_W      = $clog2(WIN_HI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_in,
   input  logic              hpol,
   input  logic              vsync_in,
   input  logic              vpol,
   output logic              vreset,
   output logic [LINE_W-1:0] line_count,
   output logic              locked
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (INTEG_CLKS < 1) begin : g_bad_integ
         $error("INTEG_CLKS must be at least 1");
      end
      if (WIN_LO < 1 || WIN_LO > WIN_HI) begin : g_bad_window
         $error("window bounds must satisfy 1 <= WIN_LO <= WIN_HI");
      end
      if (LOCK_FIELDS < 1) begin : g_bad_lock
         $error("LOCK_FIELDS must be at least 1");
      end
   endgenerate

   logic        h_lvl;
   logic        v_lvl;
   logic        v_qual;
   vsct_event_e ev;

   vsct_level_sync #(.STAGES(SYNC_STAGES)) u_hsync (
      .clk(clk), .rst_n(rst_n), .raw(hsync_in), .invert(hpol), .lvl(h_lvl)
   );

   vsct_level_sync #(.STAGES(SYNC_STAGES)) u_vsync (
      .clk(clk), .rst_n(rst_n), .raw(vsync_in), .invert(vpol), .lvl(v_lvl)
   );

   vsct_integrator #(.INTEG_CLKS(INTEG_CLKS)) u_integ (
      .clk(clk), .rst_n(rst_n), .lvl(v_lvl), .qual(v_qual)
   );

   vsct_window_ctr #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .LINE_W(LINE_W)) u_window (
      .clk(clk), .rst_n(rst_n), .qual(v_qual), .h_lvl(h_lvl),
      .line_count(line_count), .vreset(vreset), .ev(ev)
   );

   vsct_lock #(.LOCK_FIELDS(LOCK_FIELDS)) u_lock (
      .clk(clk), .rst_n(rst_n), .ev(ev), .locked(locked)
   );
endmodule

// File: rtl/vsync_countdown_chk.sv
module vsync_countdown_chk #(
   parameter int WIN_HI = 296,
   parameter int LINE_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vreset,
   input logic [LINE_W-1:0] line_count,
   input logic              locked
);
   AST_VRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vreset |=> !vreset); // R4
   AST_VRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      vreset |-> (line_count == '0)); // R4
   AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      line_count <= LINE_W'(WIN_HI)); // R9
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!vreset && line_count != $past(line_count)) |-> (line_count == $past(line_count) + 1'b1)); // R9
   AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> vreset); // R6
   AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> vreset); // R7
endmodule

bind vsync_countdown vsync_countdown_chk #(.WIN_HI(WIN_HI), .LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vreset(vreset), .line_count(line_count), .locked(locked)
);

// File: tb/vsync_countdown_bench.sv
module vsync_countdown_bench;
   localparam int CLK_PERIOD = 10;
   localparam int P_S = 2, P_IN = 6, P_LO = 10, P_HI = 14, P_LK = 4;
   localparam int LINE_CLKS = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hsync_in = 1'b0, hpol = 1'b0, vsync_in = 1'b0, vpol = 1'b0;
   logic vreset, locked;
   logic [3:0] line_count;

   int n_chk = 0, n_err = 0, vres_seen = 0, cyc = 0, carry = 0;

   vsync_countdown #(.SYNC_STAGES(P_S), .INTEG_CLKS(P_IN), .WIN_LO(P_LO),
                     .WIN_HI(P_HI), .LOCK_FIELDS(P_LK)) u_vsync_countdown (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hpol(hpol),
      .vsync_in(vsync_in), .vpol(vpol), .vreset(vreset),
      .line_count(line_count), .locked(locked));

   always #(CLK_PERIOD/2) clk = ~clk;

   // capture inputs at the edge for the reference model
   logic c_h = 0, c_v = 0, c_hp = 0, c_vp = 0, c_rst = 0, c_valid = 0;
   always @(posedge clk) begin
      c_h <= hsync_in; c_v <= vsync_in; c_hp <= hpol; c_vp <= vpol;
      c_rst <= rst_n; c_valid <= 1'b1;
      if (vreset) vres_seen <= vres_seen + 1;
   end

   // behavioural reference model, stepped once per clock
   bit hh[$], vh[$];
   int icnt = 0, lcnt = 0, gcnt = 0;
   bit m_vq = 0, m_vres = 0, m_lock = 0;

   initial begin
      for (int k = 0; k <= P_S; k++) begin hh.push_back(0); vh.push_back(0); end
   end

   always @(negedge clk) begin
      if (c_valid) begin
         if (!c_rst) begin
            icnt = 0; lcnt = 0; gcnt = 0; m_vq = 0; m_vres = 0; m_lock = 0;
            for (int k = 0; k <= P_S; k++) begin hh[k] = 0; vh[k] = 0; end
         end else begin
            bit vs, hr, nq, acc, fr;
            vs = vh[P_S-1];
            hr = hh[P_S-1] && !hh[P_S];
            nq = vs && (icnt == P_IN - 1);
            if (!vs) icnt = 0; else if (icnt < P_IN) icnt++;
            acc = m_vq && lcnt >= P_LO && lcnt <= P_HI;
            fr  = !acc && hr && lcnt == P_HI;
            if (acc || fr) lcnt = 0; else if (hr) lcnt++;
            m_vres = acc || fr;
            if (acc) begin
               if (gcnt < P_LK) gcnt++;
               if (gcnt >= P_LK) m_lock = 1;
            end
            if (fr) begin gcnt = 0; m_lock = 0; end
            m_vq = nq;
            void'(hh.pop_back()); hh.push_front(c_h ^ c_hp);
            void'(vh.pop_back()); vh.push_front(c_v ^ c_vp);
         end
         n_chk++;
         if (vreset !== m_vres || line_count !== 4'(lcnt) || locked !== m_lock) begin
            n_err++;
            $display("FAIL R4 R9 R10 R7 cycle %0d: actual vreset=%0b count=%0d locked=%0b expected %0b %0d %0b",
                     cyc, vreset, line_count, locked, m_vres, lcnt, m_lock);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_line(input bit with_v, input int vstart, input int vlen);
      int cin;
      cin = carry;
      for (int c = 0; c < LINE_CLKS; c++) begin
         @(negedge clk);
         hsync_in = (c < 2) ^ hpol;
         vsync_in = ((with_v && c >= vstart && c < vstart + vlen) || c < cin) ^ vpol;
      end
      carry = (with_v && vstart + vlen > LINE_CLKS) ? vstart + vlen - LINE_CLKS : 0;
   endtask

   task automatic wait_count(input int target);
      for (int g = 0; g < 40 && line_count != 4'(target); g++) run_line(0, 0, 0);
      chk("R9 reach count", line_count, target);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      chk("R8 vreset in reset", vreset, 0);
      chk("R8 count in reset", line_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 count after reset", line_count, 0);
      chk("R8 locked after reset", locked, 0);

      // R6: free run, one forced reset within 20 lines
      base = vres_seen;
      for (int i = 0; i < 20; i++) run_line(0, 0, 0);
      chk("R6 free-run pulses", vres_seen - base, 1);
      chk("R6 count after free run", line_count, 5);
      chk("R6 locked low", locked, 0);

      // R4: in-window pulse accepted
      wait_count(12);
      base = vres_seen;
      run_line(1, 3, 6);
      chk("R4 accepted pulse", vres_seen - base, 1);
      chk("R4 count restarted", line_count, 0);

      // R3: one clock short of integration is ignored
      wait_count(12);
      base = vres_seen;
      run_line(1, 3, P_IN - 1);
      chk("R3 short pulse ignored", vres_seen - base, 0);
      chk("R3 count kept", line_count, 13);
      run_line(1, 3, P_IN);
      chk("R3 full pulse accepted", vres_seen - base, 1);

      // R5: out-of-window pulse ignored
      wait_count(5);
      base = vres_seen;
      run_line(1, 3, 6);
      chk("R5 early pulse ignored", vres_seen - base, 0);
      chk("R5 count advanced", line_count, 6);

      // R7: third and fourth accepted fields
      wait_count(12);
      run_line(1, 3, 6);
      chk("R7 not locked after 3 fields", locked, 0);
      wait_count(12);
      run_line(1, 3, 6);
      chk("R7 locked after 4 fields", locked, 1);

      // R1: inverted vertical polarity
      vpol = 1'b1;
      wait_count(12);
      base = vres_seen;
      run_line(1, 3, 6);
      chk("R1 low-active pulse accepted", vres_seen - base, 1);
      chk("R1 lock held", locked, 1);

      // R2: inverted horizontal polarity
      hpol = 1'b1;
      for (int i = 0; i < 3; i++) run_line(0, 0, 0);
      chk("R2 lines counted low-active", line_count, 3);

      // R10: sweep pulse phase across the line edge
      for (int off = 6; off < LINE_CLKS; off++) begin
         wait_count(12);
         base = vres_seen;
         run_line(1, off, 6);
         run_line(0, 0, 0);
         chk("R10 phase sweep one vreset", vres_seen - base, 1);
         chk("R10 phase sweep lock", locked, 1);
      end

      // R6: loss of vertical drops lock
      base = vres_seen;
      for (int i = 0; i < 16; i++) run_line(0, 0, 0);
      chk("R6 forced reset after loss", vres_seen - base, 1);
      chk("R6 lock cleared", locked, 0);

      repeat (4) @(negedge clk);
      summary();
   end
endmodule